// File: doc/BRIEF.md
# Banked Auto-Increment Read Pointer

This block keeps one read-address pointer for each bank of a buffer memory, so that software can stream words out of the memory without rewriting the address before every access. Software programs a bank once: a single register write carries the starting address and a bank selector. After that, each read request that names a bank gets that bank's current pointer as the memory address, and the pointer then moves forward by one 32-bit word.

Each bank's pointer is independent. Loading a new address into one bank leaves the other banks' pointers where they were, so several streams can be interleaved. A register read-back shows the address and bank of the most recent write. The memory array and the bus timing around the block are not part of it.

Top module: `bank_rd_ptr`

## Requirements
- R1: After reset every bank pointer is zero, `memAddrValid` is 0, and `cfgAddr` and `cfgBank` are zero.
- R2: A write (`wrEn`=1) loads `wrAddr` into the pointer of the bank whose number equals the binary value of `wrBank` (0 to 3). The pointers of the other three banks do not change.
- R3: A read request (`rdEn`=1 with bank number `rdBank`) in cycle t makes `memAddrValid`=1 in cycle t+1, and `memAddr` in cycle t+1 equals that bank's pointer as it was in cycle t, before the increment.
- R4: After each read, the pointer of the bank that was read grows by 4 (one 32-bit word). The pointers of the other banks do not change.
- R5: Reads of one bank on back-to-back cycles return addresses that rise by 4 each time, until that bank is written again.
- R6: When a write and a read name the same bank in the same cycle, the read returns the old pointer, the write wins, and the next read of that bank returns the newly written address.
- R7: When a write and a read name different banks in the same cycle, both take effect: the written bank is loaded and the read bank advances by 4.
- R8: Pointers wrap modulo 2^ADDR_W: a pointer at 2^ADDR_W-4 returns that value on a read and then becomes 0.
- R9: From the cycle after a write, `cfgAddr` and `cfgBank` show the address and bank of that write, and they stay unchanged while no write occurs.
- R10: In the cycle after a cycle with no read request, `memAddrValid` is 0 and `memAddr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Start address to load |
| wrBank | input | 2 | Bank number for the write |
| rdEn | input | 1 | Read request |
| rdBank | input | 2 | Bank number for the read |
| memAddr | output | ADDR_W | Memory address for the read, registered |
| memAddrValid | output | 1 | memAddr holds the address of a read issued in the previous cycle |
| cfgAddr | output | ADDR_W | Read-back of the last written address |
| cfgBank | output | 2 | Read-back of the last written bank |

## Verification
A corrupted pointer only becomes visible at the ports when its bank is next read. The wrong address then appears on `memAddr` one cycle after the request, so each test reads every bank it touched right after the stimulus. A wrong priority between a write and a read, or a write that leaks into a neighbouring bank, shows up as a wrong address on the first read that follows. The bench therefore keeps its own model of all four pointers and compares against it on every read.

// File: rtl/bank_rd_ptr_pkg.sv
package bank_rd_ptr_pkg;

  // Width of the bank selector; the bank count follows from it.
  localparam int BANK_SEL_W = 2;
  localparam int NUM_BANKS  = 1 << BANK_SEL_W;
  // Bytes per word; the pointer step after each read.
  localparam int WORD_BYTES = 4;

  typedef logic [BANK_SEL_W-1:0] bankSel_t;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic [NUM_BANKS-1:0] loadHot;   // load wrAddr into this bank
    logic [NUM_BANKS-1:0] incHot;    // advance this bank by one word
    logic                 captureRd; // register the selected pointer
    bankSel_t             rdSel;     // bank whose pointer is captured
    logic                 recordWr;  // update read-back registers
  } ptrStrobes_t;

endpackage

// File: rtl/bank_rd_ptr_ctrl.sv
module bank_rd_ptr_ctrl
  import bank_rd_ptr_pkg::*;
(
  input  logic        wrEn,
  input  bankSel_t    wrBank,
  input  logic        rdEn,
  input  bankSel_t    rdBank,
  output ptrStrobes_t strobes
);

  logic [NUM_BANKS-1:0] wrHit;
  logic [NUM_BANKS-1:0] rdHit;

  // One decoder per bank; a load always overrides an increment.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_decode
    assign wrHit[b] = wrEn && (wrBank == BANK_SEL_W'(b));
    assign rdHit[b] = rdEn && (rdBank == BANK_SEL_W'(b));
  end

  always_comb begin
    strobes.loadHot   = wrHit;
    strobes.incHot    = rdHit & ~wrHit;
    strobes.captureRd = rdEn;
    strobes.rdSel     = rdBank;
    strobes.recordWr  = wrEn;
  end

endmodule

// File: rtl/bank_rd_ptr_datapath.sv
module bank_rd_ptr_datapath
  import bank_rd_ptr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  bankSel_t          wrBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memAddrValid,
  output logic [ADDR_W-1:0] cfgAddr,
  output bankSel_t          cfgBank
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] ptrQ [NUM_BANKS];
  logic [ADDR_W-1:0] selPtr;

  // Per-bank pointer register: load beats increment, increment wraps.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrQ[b] <= '0;
      end else if (strobes.loadHot[b]) begin
        ptrQ[b] <= wrAddr;
      end else if (strobes.incHot[b]) begin
        ptrQ[b] <= ptrQ[b] + STEP;
      end
    end
  end

  assign selPtr = ptrQ[strobes.rdSel];

  // Registered address output, pre-increment value of the chosen bank.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr      <= '0;
      memAddrValid <= 1'b0;
    end else begin
      memAddrValid <= strobes.captureRd;
      if (strobes.captureRd) begin
        memAddr <= selPtr;
      end
    end
  end

  // Read-back of the most recent write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAddr <= '0;
      cfgBank <= '0;
    end else if (strobes.recordWr) begin
      cfgAddr <= wrAddr;
      cfgBank <= wrBank;
    end
  end

endmodule

// File: rtl/bank_rd_ptr.sv
module bank_rd_ptr
  import bank_rd_ptr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrBank,
  input  logic              rdEn,
  input  logic [1:0]        rdBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memAddrValid,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [1:0]        cfgBank
);

  ptrStrobes_t strobes;

  bank_rd_ptr_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrBank  (wrBank),
    .rdEn    (rdEn),
    .rdBank  (rdBank),
    .strobes (strobes)
  );

  bank_rd_ptr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wrAddr       (wrAddr),
    .wrBank       (wrBank),
    .memAddr      (memAddr),
    .memAddrValid (memAddrValid),
    .cfgAddr      (cfgAddr),
    .cfgBank      (cfgBank)
  );

endmodule

// File: rtl/bank_rd_ptr_chk.sv
module bank_rd_ptr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [1:0]        wrBank,
  input logic              rdEn,
  input logic [1:0]        rdBank,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAddrValid,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [1:0]        cfgBank
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  // R1: reset clears the valid flag and the read-back
  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!memAddrValid && cfgAddr == '0 && cfgBank == '0));

  // R3: a request yields a valid address on the next cycle
  a_r3_valid_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> memAddrValid);

  // R10: no request, no valid, and the address holds
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (!memAddrValid && $stable(memAddr)));

  // R5: back-to-back reads of one bank, not written in between, step by one word
  a_r5_stream_step: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && memAddrValid && rstN && $past(rdEn) && rdBank == $past(rdBank)
     && !($past(wrEn) && $past(wrBank) == rdBank))
    |=> memAddr == $past(memAddr) + STEP);

  // R9: read-back follows the last write
  a_r9_readback_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (cfgAddr == $past(wrAddr) && cfgBank == $past(wrBank)));

  // R9: read-back holds without a write
  a_r9_readback_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(cfgAddr) && $stable(cfgBank)));

  // R6: a same-bank write then read returns the written address
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn) ##1 (rdEn && !wrEn && rdBank == $past(wrBank))
    |=> memAddr == $past(wrAddr, 2));

endmodule

bind bank_rd_ptr bank_rd_ptr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrAddr       (wrAddr),
  .wrBank       (wrBank),
  .rdEn         (rdEn),
  .rdBank       (rdBank),
  .memAddr      (memAddr),
  .memAddrValid (memAddrValid),
  .cfgAddr      (cfgAddr),
  .cfgBank      (cfgBank)
);

// File: tb/tb_bank_rd_ptr.sv
`timescale 1ns/1ps
module tb_bank_rd_ptr;

  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [1:0]        wrBank = '0;
  logic              rdEn = 1'b0;
  logic [1:0]        rdBank = '0;
  logic [ADDR_W-1:0] memAddr;
  logic              memAddrValid;
  logic [ADDR_W-1:0] cfgAddr;
  logic [1:0]        cfgBank;

  int checks = 0;
  int fails  = 0;
  logic [ADDR_W-1:0] model [4];

  always #2 clk = ~clk;

  bank_rd_ptr #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrBank(wrBank),
    .rdEn(rdEn), .rdBank(rdBank), .memAddr(memAddr), .memAddrValid(memAddrValid),
    .cfgAddr(cfgAddr), .cfgBank(cfgBank)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic writeBank(input logic [1:0] b, input logic [ADDR_W-1:0] a);
    wrEn = 1'b1; wrAddr = a; wrBank = b;
    tick();
    wrEn = 1'b0;
    model[b] = a;
  endtask

  task automatic readBank(input logic [1:0] b, input string req);
    rdEn = 1'b1; rdBank = b;
    tick();
    rdEn = 1'b0;
    check(req, {31'd0, memAddrValid}, 32'd1);
    check(req, 32'(memAddr), 32'(model[b]));
    model[b] = model[b] + ADDR_W'(4);
  endtask

  task automatic testReset();
    for (int i = 0; i < 4; i++) model[i] = '0;
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    check("R1 valid", {31'd0, memAddrValid}, 32'd0);
    check("R1 cfgAddr", 32'(cfgAddr), 32'd0);
    check("R1 cfgBank", 32'(cfgBank), 32'd0);
    for (int i = 0; i < 4; i++) readBank(2'(i), "R1 pointer zero");
  endtask

  task automatic testLoadIsolation();
    writeBank(2'd2, 16'h1000);
    readBank(2'd2, "R2 loaded bank");
    readBank(2'd0, "R2 other bank untouched");
    readBank(2'd1, "R2 other bank untouched");
    readBank(2'd3, "R2 other bank untouched");
    readBank(2'd2, "R4 advance by word");
  endtask

  task automatic testStream();
    logic [ADDR_W-1:0] exp;
    writeBank(2'd1, 16'h0200);
    exp = 16'h0200;
    rdEn = 1'b1; rdBank = 2'd1;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R5 stream valid", {31'd0, memAddrValid}, 32'd1);
      check("R5 stream addr", 32'(memAddr), 32'(exp));
      exp = exp + 16'd4;
    end
    rdEn = 1'b0;
    model[1] = exp;
    readBank(2'd0, "R4 idle bank after stream");
    readBank(2'd1, "R5 continues after pause");
  endtask

  task automatic testSameCycle();
    logic [ADDR_W-1:0] old;
    old = model[3];
    wrEn = 1'b1; wrAddr = 16'h3330; wrBank = 2'd3;
    rdEn = 1'b1; rdBank = 2'd3;
    tick();
    wrEn = 1'b0; rdEn = 1'b0;
    check("R6 read returns old pointer", 32'(memAddr), 32'(old));
    model[3] = 16'h3330;
    readBank(2'd3, "R6 write wins");
  endtask

  task automatic testCrossBank();
    logic [ADDR_W-1:0] old;
    old = model[1];
    wrEn = 1'b1; wrAddr = 16'h0A00; wrBank = 2'd0;
    rdEn = 1'b1; rdBank = 2'd1;
    tick();
    wrEn = 1'b0; rdEn = 1'b0;
    check("R7 read other bank", 32'(memAddr), 32'(old));
    model[0] = 16'h0A00;
    model[1] = old + 16'd4;
    readBank(2'd0, "R7 written bank loaded");
    readBank(2'd1, "R7 read bank advanced");
  endtask

  task automatic testWrap();
    writeBank(2'd2, 16'hFFFC);
    readBank(2'd2, "R8 top of range");
    readBank(2'd2, "R8 wrapped to zero");
  endtask

  task automatic testReadback();
    writeBank(2'd3, 16'h7770);
    check("R9 cfgAddr", 32'(cfgAddr), 32'h7770);
    check("R9 cfgBank", 32'(cfgBank), 32'd3);
    readBank(2'd0, "R9 read between");
    check("R9 cfgAddr hold", 32'(cfgAddr), 32'h7770);
    check("R9 cfgBank hold", 32'(cfgBank), 32'd3);
  endtask

  task automatic testIdle();
    logic [ADDR_W-1:0] last;
    readBank(2'd1, "R10 prime");
    last = memAddr;
    tick();
    check("R10 valid low", {31'd0, memAddrValid}, 32'd0);
    check("R10 addr holds", 32'(memAddr), 32'(last));
  endtask

  initial begin
    fork
      begin
        testReset();
        testLoadIsolation();
        testStream();
        testSameCycle();
        testCrossBank();
        testWrap();
        testReadback();
        testIdle();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule